// File: doc/BRIEF.md
# Receive Time-out Counter/Timer

This block is a 16-bit programmable down-counter shared by a pair of serial receive channels. It runs in one of three modes. In counter mode it counts down once from a loaded divisor and flags expiry. In timer mode it reloads without stopping and produces a square wave. In receive time-out mode the count is controlled by the received data stream, so the host learns when the line has gone quiet with characters still waiting in a receive FIFO. All counting happens on a single-cycle count-enable input. A slower clock domain feeds this input through a strobe, so this block has no clock muxing.

The host programs the block through a small byte-wide write port. The port carries two preset bytes, a configuration byte, an interrupt mask byte and a command byte. In time-out mode each channel pulses a transfer input when it moves a character into its FIFO. A transfer arms a reload that happens on the next count tick. If the count then runs to zero with no further transfer, the counter-ready flag sets and, when unmasked, the interrupt output rises.

Top module: `rxto_ctr`

## Requirements
- R1: After reset the count output, counter-ready, interrupt and square-wave output are all 0, and time-out mode is off.
- R2: The divisor is {upper preset (address 1), lower preset (address 0)}. A divisor of 0 or 1 is loaded as 2. Writing a preset never changes a count already running.
- R3: The count changes only on a clock edge where the count-enable input is high, or on a start command. In all other cycles it holds.
- R4: With configuration bit 0 (address 2) at 0 (counter mode), a command byte (address 4) whose upper nibble is 0x8 loads the divisor on that edge, clears counter-ready and runs. Each tick then decrements the count. The tick that reaches 0 sets counter-ready and stops the count.
- R5: With configuration bit 0 at 1 (timer mode), start loads the divisor and clears the square output. A tick with the count at 1 reloads the divisor and inverts the square output. Counter-ready sets when the square output falls. The full period is twice the divisor.
- R6: Outside time-out mode, a command with upper nibble 0x9 stops the count, keeps its value and clears counter-ready.
- R7: The interrupt output is high exactly when counter-ready is set and bit 3 of the mask byte (address 3) is set.
- R8: A command with upper nibble 0xA (lower nibble ignored) enables time-out mode, clears counter-ready and holds the count stopped until a character transfer occurs.
- R9: In time-out mode, a transfer pulse from either channel clears counter-ready and holds the count. This takes priority over a tick in the same cycle. The next tick reloads the divisor, and later ticks decrement. Reaching 0 sets counter-ready and stops the count.
- R10: While time-out mode is on, start and stop commands have no effect.
- R11: A command with upper nibble 0xC turns time-out mode off and stops the count. After that, transfer pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 lower preset, 1 upper preset, 2 config, 3 mask, 4 command |
| wr_data | input | 8 | Write data |
| rx_xfer | input | NCH | Per-channel pulse: a character entered that channel's receive FIFO |
| count_val | output | 16 | Current count |
| ctr_ready | output | 1 | Counter-ready flag |
| irq | output | 1 | Masked interrupt |
| sq_out | output | 1 | Timer-mode square wave |

## Verification
The bench builds the block with its defaults: a 16-bit count made from two 8-bit presets and two channels. Two channels are enough to show a transfer from either one restarting a shared time-out. A transfer on the second channel that lands on a tick checks the priority rule. The full 16-bit width lets an upper-byte divisor of 256 show byte assembly, and a small divisor of 3 or 4 brings the zero crossing, the timer reload and the divisor clamp within a few dozen cycles.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  typedef enum logic [3:0] {
    CMD_START  = 4'h8,
    CMD_STOP   = 4'h9,
    CMD_TO_ON  = 4'hA,
    CMD_TO_OFF = 4'hC
  } cmd_e;

  localparam logic [2:0] A_PLO  = 3'd0;
  localparam logic [2:0] A_PHI  = 3'd1;
  localparam logic [2:0] A_CFG  = 3'd2;
  localparam logic [2:0] A_MASK = 3'd3;
  localparam logic [2:0] A_CMD  = 3'd4;
endpackage

// File: rtl/rxto_regs.sv
module rxto_regs
  import rxto_pkg::*;
#(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [BW-1:0] wr_data,
  output logic [CW-1:0] preset,
  output logic          timer_mode,
  output logic          mask_rdy,
  output logic          cmd_start,
  output logic          cmd_stop,
  output logic          cmd_to_on,
  output logic          cmd_to_off
);
  logic [BW-1:0] plo_q, phi_q;
  logic [CW-1:0] raw;
  logic          hit_cmd;
  logic [3:0]    op;

  always_ff @(posedge clk) begin
    if (rst) begin
      plo_q      <= '0;
      phi_q      <= '0;
      timer_mode <= 1'b0;
      mask_rdy   <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_PLO:   plo_q      <= wr_data;
        A_PHI:   phi_q      <= wr_data;
        A_CFG:   timer_mode <= wr_data[0];
        A_MASK:  mask_rdy   <= wr_data[3];
        default: ;
      endcase
    end
  end

  // divisor clamp: values below 2 are not legal
  assign raw    = {phi_q, plo_q};
  assign preset = (raw < CW'(2)) ? CW'(2) : raw;

  assign hit_cmd    = wr_en && (wr_addr == A_CMD);
  assign op         = wr_data[BW-1 -: 4];
  assign cmd_start  = hit_cmd && (op == CMD_START);
  assign cmd_stop   = hit_cmd && (op == CMD_STOP);
  assign cmd_to_on  = hit_cmd && (op == CMD_TO_ON);
  assign cmd_to_off = hit_cmd && (op == CMD_TO_OFF);
endmodule

// File: rtl/rxto_trig.sv
module rxto_trig #(
  parameter int NCH = 2
) (
  input  logic [NCH-1:0] rx_xfer,
  output logic           xfer_any
);
  logic [NCH:0] acc;
  assign acc[0] = 1'b0;
  for (genvar gi = 0; gi < NCH; gi++) begin : g_or
    assign acc[gi+1] = acc[gi] | rx_xfer[gi];
  end
  assign xfer_any = acc[NCH];
endmodule

// File: rtl/rxto_core.sv
module rxto_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          xfer_any,
  input  logic [CW-1:0] preset,
  input  logic          timer_mode,
  input  logic          cmd_start,
  input  logic          cmd_stop,
  input  logic          cmd_to_on,
  input  logic          cmd_to_off,
  output logic [CW-1:0] cnt,
  output logic          ready,
  output logic          sq
);
  logic run, pend, to_mode;
  logic last;

  assign last = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; ready <= 1'b0; sq <= 1'b0;
      run <= 1'b0; pend <= 1'b0; to_mode <= 1'b0;
    end else if (cmd_to_on) begin
      to_mode <= 1'b1; ready <= 1'b0; run <= 1'b0; pend <= 1'b0;
    end else if (cmd_to_off) begin
      to_mode <= 1'b0; run <= 1'b0; pend <= 1'b0;
    end else if (to_mode) begin
      if (xfer_any) begin
        pend <= 1'b1; ready <= 1'b0; run <= 1'b0;
      end else if (tick && pend) begin
        cnt <= preset; run <= 1'b1; pend <= 1'b0;
      end else if (tick && run) begin
        cnt <= cnt - CW'(1);
        if (last) begin
          run <= 1'b0; ready <= 1'b1;
        end
      end
    end else begin
      if (cmd_start) begin
        cnt <= preset; run <= 1'b1; ready <= 1'b0;
        if (timer_mode) sq <= 1'b0;
      end else if (cmd_stop) begin
        run <= 1'b0; ready <= 1'b0;
      end else if (tick && run) begin
        if (last && timer_mode) begin
          cnt <= preset;
          sq  <= ~sq;
          if (sq) ready <= 1'b1;
        end else if (last) begin
          cnt <= '0; run <= 1'b0; ready <= 1'b1;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end
  end

  // R1/R4: a running count never sits at zero
  a_r4_run_nonzero: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt != '0));
  // R3: without tick or start the count holds
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cmd_start) |=> $stable(cnt));
  // R8: arming time-out leaves the counter idle and not ready
  a_r8_arm: assert property (@(posedge clk) disable iff (rst)
    cmd_to_on |=> (!ready && !run));
  // R9: a transfer in time-out mode withdraws counter-ready
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    (to_mode && xfer_any && !cmd_to_on && !cmd_to_off) |=> !ready);
  // R9: the stopped tick after a transfer reloads the divisor
  a_r9_reload: assert property (@(posedge clk) disable iff (rst)
    (to_mode && pend && tick && !xfer_any && !cmd_to_on && !cmd_to_off)
      |=> (cnt == $past(preset)));
endmodule

// File: rtl/rxto_ctr.sv
module rxto_ctr
  import rxto_pkg::*;
#(
  parameter int BW  = 8,
  parameter int NCH = 2,
  localparam int CW = 2 * BW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           wr_en,
  input  logic [2:0]     wr_addr,
  input  logic [BW-1:0]  wr_data,
  input  logic [NCH-1:0] rx_xfer,
  output logic [CW-1:0]  count_val,
  output logic           ctr_ready,
  output logic           irq,
  output logic           sq_out
);
  logic [CW-1:0] preset;
  logic timer_mode, mask_rdy, xfer_any;
  logic cmd_start, cmd_stop, cmd_to_on, cmd_to_off;

  rxto_regs #(.BW(BW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .preset(preset), .timer_mode(timer_mode), .mask_rdy(mask_rdy),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_to_on(cmd_to_on), .cmd_to_off(cmd_to_off)
  );

  rxto_trig #(.NCH(NCH)) u_trig (.rx_xfer(rx_xfer), .xfer_any(xfer_any));

  rxto_core #(.CW(CW)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .xfer_any(xfer_any), .preset(preset),
    .timer_mode(timer_mode), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_to_on(cmd_to_on), .cmd_to_off(cmd_to_off),
    .cnt(count_val), .ready(ctr_ready), .sq(sq_out)
  );

  assign irq = ctr_ready & mask_rdy;

  // R7: interrupt never raised without counter-ready
  a_r7_irq_needs_ready: assert property (@(posedge clk) disable iff (rst)
    irq |-> ctr_ready);
endmodule

// File: tb/rxto_ctr_test.sv
module rxto_ctr_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  rx_xfer = '0;
  logic [15:0] count_val;
  logic        ctr_ready, irq, sq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    string tag;
    int    c;
    bit    r;
    bit    i;
    bit    s;
  } exp_t;
  exp_t q[$];

  always #(CLK_NS/2) clk = ~clk;

  rxto_ctr uut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rx_xfer(rx_xfer), .count_val(count_val),
    .ctr_ready(ctr_ready), .irq(irq), .sq_out(sq_out)
  );

  // monitor: compare outputs mid-cycle against queued expectations
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (count_val != 16'(e.c) || ctr_ready != e.r || irq != e.i || sq_out != e.s) begin
        fails++;
        $display("FAIL %s: actual cnt=%0d rdy=%0b irq=%0b sq=%0b expected cnt=%0d rdy=%0b irq=%0b sq=%0b",
                 e.tag, count_val, ctr_ready, irq, sq_out, e.c, e.r, e.i, e.s);
      end
    end
  end

  task automatic step(input bit we, input logic [2:0] a, input logic [7:0] d,
                      input logic [1:0] xf, input bit tk);
    wr_en = we; wr_addr = a; wr_data = d; rx_xfer = xf; tick = tk;
    @(posedge clk); #1;
    wr_en = 1'b0; rx_xfer = '0; tick = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step(1'b1, a, d, 2'b00, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 3'd0, 8'h00, 2'b00, 1'b1);
  endtask

  task automatic xf(input logic [1:0] ch, input bit tk);
    step(1'b0, 3'd0, 8'h00, ch, tk);
  endtask

  task automatic expect_out(input string tag, input int c, input bit r, input bit i, input bit s);
    exp_t e;
    e.tag = tag; e.c = c; e.r = r; e.i = i; e.s = s;
    q.push_back(e);
  endtask

  initial begin
    #(CLK_NS * 50000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) step(1'b0, 3'd0, 8'h00, 2'b00, 1'b0);
    expect_out("R1 reset state", 0, 0, 0, 0);
    rst = 1'b0;
    @(posedge clk); #1;

    // counter mode
    wr(3'd3, 8'h08); wr(3'd2, 8'h00); wr(3'd0, 8'd5); wr(3'd1, 8'd0);
    wr(3'd4, 8'h80); expect_out("R4 start loads", 5, 0, 0, 0);
    step(1'b0, 3'd0, 8'h00, 2'b00, 1'b0); expect_out("R3 idle holds", 5, 0, 0, 0);
    ticks(4); expect_out("R4 decrement", 1, 0, 0, 0);
    ticks(1); expect_out("R4 R7 zero sets ready irq", 0, 1, 1, 0);
    ticks(1); expect_out("R4 stopped at zero", 0, 1, 1, 0);
    wr(3'd4, 8'h90); expect_out("R6 stop clears ready", 0, 0, 0, 0);

    // divisor assembly and clamp
    wr(3'd0, 8'd1); wr(3'd4, 8'h80); expect_out("R2 clamp one", 2, 0, 0, 0);
    wr(3'd0, 8'd0); wr(3'd4, 8'h80); expect_out("R2 clamp zero", 2, 0, 0, 0);
    wr(3'd1, 8'd1); wr(3'd4, 8'h80); expect_out("R2 upper byte", 256, 0, 0, 0);
    wr(3'd0, 8'd3); wr(3'd1, 8'd0); expect_out("R2 preset write no disturb", 256, 0, 0, 0);
    ticks(1); expect_out("R2 count continues", 255, 0, 0, 0);
    wr(3'd4, 8'h90); expect_out("R6 stop holds value", 255, 0, 0, 0);

    // timer mode, divisor 3
    wr(3'd2, 8'h01); wr(3'd4, 8'h80); expect_out("R5 timer start", 3, 0, 0, 0);
    ticks(2); expect_out("R5 timer count", 1, 0, 0, 0);
    ticks(1); expect_out("R5 reload toggles high", 3, 0, 0, 1);
    ticks(3); expect_out("R5 falling sets ready", 3, 1, 1, 0);
    wr(3'd4, 8'h90); expect_out("R6 stop timer", 3, 0, 0, 0);

    // receive time-out mode, divisor 4
    wr(3'd0, 8'd4);
    wr(3'd4, 8'hA5); expect_out("R8 arm", 3, 0, 0, 0);
    ticks(3); expect_out("R8 held until transfer", 3, 0, 0, 0);
    wr(3'd4, 8'h80); expect_out("R10 start ignored", 3, 0, 0, 0);
    ticks(1); expect_out("R10 still stopped", 3, 0, 0, 0);
    xf(2'b01, 1'b0); expect_out("R9 transfer holds", 3, 0, 0, 0);
    ticks(1); expect_out("R9 reload on tick", 4, 0, 0, 0);
    ticks(3); expect_out("R9 decrement", 1, 0, 0, 0);
    xf(2'b10, 1'b1); expect_out("R9 transfer beats tick", 1, 0, 0, 0);
    ticks(1); expect_out("R9 reload other channel", 4, 0, 0, 0);
    ticks(4); expect_out("R9 R7 timeout fires", 0, 1, 1, 0);
    wr(3'd4, 8'h90); expect_out("R10 stop ignored", 0, 1, 1, 0);
    xf(2'b01, 1'b0); expect_out("R9 transfer withdraws", 0, 0, 0, 0);
    ticks(1); expect_out("R9 reload again", 4, 0, 0, 0);
    wr(3'd4, 8'hA0); ticks(1); expect_out("R8 rearm stops", 4, 0, 0, 0);
    wr(3'd3, 8'h00); xf(2'b01, 1'b0); ticks(1); ticks(4);
    expect_out("R7 masked timeout", 0, 1, 0, 0);
    wr(3'd4, 8'hC0); expect_out("R11 mode off", 0, 1, 0, 0);
    xf(2'b01, 1'b0); expect_out("R11 transfer ignored", 0, 1, 0, 0);
    ticks(1); expect_out("R11 no reload", 0, 1, 0, 0);
    wr(3'd4, 8'h90); expect_out("R6 stop works again", 0, 0, 0, 0);

    @(posedge clk); @(posedge clk); #1;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule